// File: doc/BRIEF.md
# Lockable Configuration Store Controller

This block guards a small configuration word array behind a one-command-per-cycle interface. A host can bulk-erase the array, program a word, read a word back, write and read a signature register, and set a security lock. It can also program a word and set the lock in the same command. Every command finishes in one clock. It then raises a one-cycle completion pulse with an accept/refuse status.

While the lock is set, every command that would read or alter array contents, or alter the signature, is refused. A refused command changes nothing. Reading the signature stays permitted at all times, so a locked store can still report which pattern and revision it holds. The only way out of the locked state is a bulk erase. It wipes the array back to the unconnected value (all ones), clears the signature and drops the lock.

The signature width is a parameter, meant to be 24 or 64 bits. The array is inferred as plain block memory. The erased state is tracked separately, so erase takes a single cycle.

Top module: `cfg_lock_ctrl`

## Requirements
- R1: After synchronous reset, `locked` and `done` are 0, the read outputs are 0, and every array word reads back as the erased value (all ones).
- R2: A command presented with `cmd_valid` high on a clock edge produces `done` high for exactly the following cycle. With no command, `done` stays low.
- R3: Program (op 1) stores `cmd_wdata` at `cmd_addr` when unlocked. Verify (op 2) then returns that word on `rd_data` with `cmd_ok` = 1.
- R4: A word never programmed since reset or the last erase reads back as all ones.
- R5: Lock (op 3) sets `locked` and is always accepted. Program-and-lock (op 6) stores the word and sets `locked` in one command.
- R6: While locked, program, verify, signature write and program-and-lock (ops 1, 2, 5, 6) return `cmd_ok` = 0 and leave the array, the signature and the lock unchanged.
- R7: A refused verify drives all zeros on `rd_data` in its `done` cycle.
- R8: Signature read (op 4) is always accepted and returns the signature on `sig_rdata`, locked or not.
- R9: Erase (op 0) is always accepted. It returns every word to all ones, clears the signature to zero and clears `locked`.
- R10: Signature write (op 5) stores `cmd_sig` when unlocked.
- R11: Op 7 is reserved. It is refused and changes no state.
- R12: `rd_data` and `sig_rdata` are zero in every cycle except the `done` cycle of an accepted verify or signature read, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0 erase, 1 program, 2 verify, 3 lock, 4 sig read, 5 sig write, 6 program+lock, 7 reserved) |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Word to program |
| cmd_sig | input | SIG_W | Signature to store |
| done | output | 1 | One-cycle completion pulse |
| cmd_ok | output | 1 | Command accepted (valid with done) |
| locked | output | 1 | Security lock state |
| rd_data | output | DATA_W | Verify result |
| sig_rdata | output | SIG_W | Signature read result |

## Verification
Some properties are checked on every cycle: the completion pulse tracks the command one cycle later, the lock stays set until an erase, and an erase leaves the lock, signature and erased-word flags cleared. No array write is ever enabled while locked, a refused read shows zeros, and a signature read is never refused. Several results can only be shown by the bench's directed scenarios, because they depend on a whole command sequence. These are data retention across commands, the all-ones value of unwritten words after an erase, a refused program leaving the old word intact after unlock is impossible without erase, and a reserved code having no effect.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

  typedef enum logic [2:0] {
    OP_ERASE     = 3'd0,
    OP_PROG      = 3'd1,
    OP_VERIFY    = 3'd2,
    OP_LOCK      = 3'd3,
    OP_SIG_RD    = 3'd4,
    OP_SIG_WR    = 3'd5,
    OP_PROG_LOCK = 3'd6,
    OP_RSVD      = 3'd7
  } cfg_op_e;

  typedef struct packed {
    logic accept;
    logic mem_we;
    logic mem_rd;
    logic sig_we;
    logic sig_rd;
    logic set_lock;
    logic wipe;
  } cfg_ctl_t;

endpackage

// File: rtl/cfg_lock_decode.sv
module cfg_lock_decode
  import cfg_lock_pkg::*;
(
  input  logic       valid_i,
  input  logic [2:0] op_i,
  input  logic       locked_i,
  output cfg_ctl_t   ctl_o
);

  always_comb begin
    ctl_o = '0;
    if (valid_i) begin
      case (cfg_op_e'(op_i))
        OP_ERASE: begin
          ctl_o.accept = 1'b1;
          ctl_o.wipe   = 1'b1;
        end
        OP_PROG: begin
          ctl_o.accept = !locked_i;
          ctl_o.mem_we = !locked_i;
        end
        OP_VERIFY: begin
          ctl_o.accept = !locked_i;
          ctl_o.mem_rd = !locked_i;
        end
        OP_LOCK: begin
          ctl_o.accept   = 1'b1;
          ctl_o.set_lock = 1'b1;
        end
        OP_SIG_RD: begin
          ctl_o.accept = 1'b1;
          ctl_o.sig_rd = 1'b1;
        end
        OP_SIG_WR: begin
          ctl_o.accept = !locked_i;
          ctl_o.sig_we = !locked_i;
        end
        OP_PROG_LOCK: begin
          ctl_o.accept   = !locked_i;
          ctl_o.mem_we   = !locked_i;
          ctl_o.set_lock = !locked_i;
        end
        default: ctl_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/cfg_lock_store.sv
module cfg_lock_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wipe_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] ERASED = '1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  written_q;
  logic [DATA_W-1:0] word_q;
  logic              word_written_q;

  // Array without reset so it maps onto block memory
  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
    word_q <= mem[addr_i];
  end

  // Per-word programmed flags: erase clears all of them in one cycle
  always_ff @(posedge clk) begin
    if (rst || wipe_i) begin
      written_q      <= '0;
      word_written_q <= 1'b0;
    end else begin
      if (we_i) written_q[addr_i] <= 1'b1;
      word_written_q <= written_q[addr_i];
    end
  end

  assign rdata_o = word_written_q ? word_q : ERASED;

  AST_WIPE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    wipe_i |=> (written_q == '0)); // R9

endmodule

// File: rtl/cfg_lock_state.sv
module cfg_lock_state
  import cfg_lock_pkg::*;
#(
  parameter int SIG_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  cfg_ctl_t         ctl_i,
  input  logic [SIG_W-1:0] sig_wdata_i,
  output logic             locked_o,
  output logic             done_o,
  output logic             ok_o,
  output logic             word_sel_o,
  output logic             sig_sel_o,
  output logic [SIG_W-1:0] sig_o
);

  logic             locked_q, done_q, ok_q, word_sel_q, sig_sel_q;
  logic [SIG_W-1:0] sig_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q   <= 1'b0;
      done_q     <= 1'b0;
      ok_q       <= 1'b0;
      word_sel_q <= 1'b0;
      sig_sel_q  <= 1'b0;
      sig_q      <= '0;
    end else begin
      done_q     <= valid_i;
      ok_q       <= ctl_i.accept;
      word_sel_q <= ctl_i.mem_rd;
      sig_sel_q  <= ctl_i.sig_rd;
      if (ctl_i.wipe) begin
        locked_q <= 1'b0;
        sig_q    <= '0;
      end else begin
        if (ctl_i.set_lock) locked_q <= 1'b1;
        if (ctl_i.sig_we)   sig_q    <= sig_wdata_i;
      end
    end
  end

  assign locked_o   = locked_q;
  assign done_o     = done_q;
  assign ok_o       = ok_q;
  assign word_sel_o = word_sel_q;
  assign sig_sel_o  = sig_sel_q;
  assign sig_o      = sig_q;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (locked_q && !ctl_i.wipe) |=> locked_q); // R6

  AST_ERASE_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
    ctl_i.wipe |=> (!locked_q && sig_q == '0)); // R9

endmodule

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl
  import cfg_lock_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int SIG_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [SIG_W-1:0]  cmd_sig,
  output logic              done,
  output logic              cmd_ok,
  output logic              locked,
  output logic [DATA_W-1:0] rd_data,
  output logic [SIG_W-1:0]  sig_rdata
);

  cfg_ctl_t          ctl;
  logic              word_sel, sig_sel;
  logic [DATA_W-1:0] store_word;
  logic [SIG_W-1:0]  sig_val;

  cfg_lock_decode u_decode (
    .valid_i  (cmd_valid),
    .op_i     (cmd_op),
    .locked_i (locked),
    .ctl_o    (ctl)
  );

  cfg_lock_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wipe_i  (ctl.wipe),
    .we_i    (ctl.mem_we),
    .addr_i  (cmd_addr),
    .wdata_i (cmd_wdata),
    .rdata_o (store_word)
  );

  cfg_lock_state #(.SIG_W(SIG_W)) u_state (
    .clk         (clk),
    .rst         (rst),
    .valid_i     (cmd_valid),
    .ctl_i       (ctl),
    .sig_wdata_i (cmd_sig),
    .locked_o    (locked),
    .done_o      (done),
    .ok_o        (cmd_ok),
    .word_sel_o  (word_sel),
    .sig_sel_o   (sig_sel),
    .sig_o       (sig_val)
  );

  assign rd_data   = word_sel ? store_word : '0;
  assign sig_rdata = sig_sel  ? sig_val    : '0;

  AST_DONE_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> done); // R2

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !done); // R2

  AST_REFUSED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && !cmd_ok) |-> (rd_data == '0 && sig_rdata == '0)); // R7

  AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    locked |-> (!ctl.mem_we && !ctl.sig_we)); // R6

  AST_SIG_ALWAYS_READ: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd4) |=> cmd_ok); // R8

endmodule

// File: tb/cfg_lock_ctrl_tb_top.sv
module cfg_lock_ctrl_tb_top;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam int SW = 24;
  localparam logic [DW-1:0] ERASED = '1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [SW-1:0] cmd_sig = '0;
  logic          done, cmd_ok, locked;
  logic [DW-1:0] rd_data;
  logic [SW-1:0] sig_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cfg_lock_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SIG_W(SW)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_sig(cmd_sig),
    .done(done), .cmd_ok(cmd_ok), .locked(locked),
    .rd_data(rd_data), .sig_rdata(sig_rdata)
  );

  task automatic check(input bit cond, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One command; captures outputs in its done cycle and checks the idle cycle after
  task automatic do_cmd(input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [SW-1:0] s,
                        output logic ok, output logic [DW-1:0] rd,
                        output logic [SW-1:0] sr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_sig = s;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(done == 1'b1, "R2 done pulse", 64'(done), 64'd1);
    ok = cmd_ok; rd = rd_data; sr = sig_rdata;
    @(negedge clk);
    check(done == 1'b0, "R2 done single cycle", 64'(done), 64'd0);
    check(rd_data == '0 && sig_rdata == '0, "R12 outputs idle zero",
          64'(rd_data) | 64'(sig_rdata), 64'd0);
  endtask

  task automatic verify_word(input logic [AW-1:0] a, input logic exp_ok,
                             input logic [DW-1:0] exp, input string req);
    logic ok; logic [DW-1:0] rd; logic [SW-1:0] sr;
    do_cmd(3'd2, a, '0, '0, ok, rd, sr);
    check(ok == exp_ok, {req, " verify status"}, 64'(ok), 64'(exp_ok));
    check(rd == exp, {req, " verify data"}, 64'(rd), 64'(exp));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(locked == 1'b0, "R1 locked after reset", 64'(locked), 64'd0);
    check(done == 1'b0, "R1 done after reset", 64'(done), 64'd0);
    check(rd_data == '0, "R1 rd_data after reset", 64'(rd_data), 64'd0);
    verify_word(4'd0, 1'b1, ERASED, "R1");
    verify_word(4'd15, 1'b1, ERASED, "R4");
  endtask

  task automatic t_prog_verify();
    logic ok; logic [DW-1:0] rd; logic [SW-1:0] sr;
    do_cmd(3'd1, 4'd3, 16'hA5C3, '0, ok, rd, sr);
    check(ok, "R3 program accepted", 64'(ok), 64'd1);
    do_cmd(3'd1, 4'd9, 16'h0000, '0, ok, rd, sr);
    do_cmd(3'd1, 4'd15, 16'h1234, '0, ok, rd, sr);
    verify_word(4'd3, 1'b1, 16'hA5C3, "R3");
    verify_word(4'd9, 1'b1, 16'h0000, "R3");
    verify_word(4'd15, 1'b1, 16'h1234, "R3");
    verify_word(4'd4, 1'b1, ERASED, "R4");
    check(rd_data == '0, "R12 idle after verify", 64'(rd_data), 64'd0);
  endtask

  task automatic t_sig_write();
    logic ok; logic [DW-1:0] rd; logic [SW-1:0] sr;
    do_cmd(3'd5, '0, '0, 24'hC0FFEE, ok, rd, sr);
    check(ok, "R10 sig write accepted", 64'(ok), 64'd1);
    check(sr == '0, "R12 sig write shows no sig", 64'(sr), 64'd0);
    do_cmd(3'd4, '0, '0, '0, ok, rd, sr);
    check(ok, "R8 sig read accepted", 64'(ok), 64'd1);
    check(sr == 24'hC0FFEE, "R10 sig value", 64'(sr), 64'hC0FFEE);
  endtask

  task automatic t_lock_blocks();
    logic ok; logic [DW-1:0] rd; logic [SW-1:0] sr;
    do_cmd(3'd3, '0, '0, '0, ok, rd, sr);
    check(ok, "R5 lock accepted", 64'(ok), 64'd1);
    check(locked, "R5 locked set", 64'(locked), 64'd1);
    do_cmd(3'd1, 4'd3, 16'h0F0F, '0, ok, rd, sr);
    check(!ok, "R6 program refused", 64'(ok), 64'd0);
    verify_word(4'd3, 1'b0, 16'h0000, "R7");
    do_cmd(3'd5, '0, '0, 24'h111111, ok, rd, sr);
    check(!ok, "R6 sig write refused", 64'(ok), 64'd0);
    do_cmd(3'd6, 4'd5, 16'h5555, '0, ok, rd, sr);
    check(!ok, "R6 program-lock refused", 64'(ok), 64'd0);
    do_cmd(3'd4, '0, '0, '0, ok, rd, sr);
    check(ok, "R8 sig read while locked", 64'(ok), 64'd1);
    check(sr == 24'hC0FFEE, "R8 sig unchanged while locked", 64'(sr), 64'hC0FFEE);
    do_cmd(3'd3, '0, '0, '0, ok, rd, sr);
    check(ok && locked, "R5 relock accepted", 64'(ok), 64'd1);
    do_cmd(3'd7, '0, '0, '0, ok, rd, sr);
    check(!ok && locked, "R11 reserved refused while locked", 64'(ok), 64'd0);
  endtask

  task automatic t_erase_unlocks();
    logic ok; logic [DW-1:0] rd; logic [SW-1:0] sr;
    do_cmd(3'd0, '0, '0, '0, ok, rd, sr);
    check(ok, "R9 erase accepted", 64'(ok), 64'd1);
    check(!locked, "R9 unlocked", 64'(locked), 64'd0);
    verify_word(4'd3, 1'b1, ERASED, "R9");
    verify_word(4'd15, 1'b1, ERASED, "R9");
    do_cmd(3'd4, '0, '0, '0, ok, rd, sr);
    check(sr == '0, "R9 sig cleared", 64'(sr), 64'd0);
  endtask

  task automatic t_prog_lock();
    logic ok; logic [DW-1:0] rd; logic [SW-1:0] sr;
    do_cmd(3'd6, 4'd7, 16'hBEEF, '0, ok, rd, sr);
    check(ok, "R5 program-lock accepted", 64'(ok), 64'd1);
    check(locked, "R5 program-lock locks", 64'(locked), 64'd1);
    verify_word(4'd7, 1'b0, 16'h0000, "R6");
    do_cmd(3'd0, '0, '0, '0, ok, rd, sr);
    verify_word(4'd7, 1'b1, ERASED, "R9");
  endtask

  task automatic t_reserved_unlocked();
    logic ok; logic [DW-1:0] rd; logic [SW-1:0] sr;
    do_cmd(3'd1, 4'd2, 16'h00FF, '0, ok, rd, sr);
    do_cmd(3'd7, 4'd2, 16'h7777, 24'h777777, ok, rd, sr);
    check(!ok, "R11 reserved refused", 64'(ok), 64'd0);
    check(!locked, "R11 no lock change", 64'(locked), 64'd0);
    verify_word(4'd2, 1'b1, 16'h00FF, "R11");
    do_cmd(3'd4, '0, '0, '0, ok, rd, sr);
    check(sr == '0, "R11 sig unchanged", 64'(sr), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_prog_verify();
    t_sig_write();
    t_lock_blocks();
    t_erase_unlocks();
    t_prog_lock();
    t_reserved_unlocked();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule